// File: doc/BRIEF.md
# Ring bracket access checker

This block decides whether one data read into a segmented, ring-protected address space may go ahead. A request carries the segment descriptor fields that govern reads: three ring bracket limits, a read-permit flag and a 14-bit segment bound. It also carries the effective ring and target segment of the access, the ring and segment of the running procedure, and the 18-bit word offset. Every check is evaluated on the same request, and the results are merged into a single coded violation mask. One combined access fault is raised whenever any bit of that mask is set.

When the descriptor grants no read permission, the block replaces the effective ring with the procedure ring. The adjusted ring travels with the mask. The checking logic is purely combinational. Its results are captured in one output register that follows a valid/ready handshake, so a consumer that is not ready stalls the block without losing a result.

Top module: `ring_access_chk`

## Requirements
- R1: Mask bit 0 (bracket order) is set unless the descriptor rings satisfy first <= second <= third.
- R2: Mask bit 3 (read bracket) is set when the request's effective ring is greater than the second bracket limit. The comparison uses the ring as presented, before any adjustment.
- R3: `ring_out` equals the procedure ring when the read-permit input is 0, and the effective ring when it is 1.
- R4: Mask bit 4 (no read) is set when the read-permit input is 0 and the procedure segment differs from the target segment.
- R5: Mask bit 15 (out of bounds) is set when the word offset shifted right by 4, kept to 14 bits, is strictly greater than the bound. Equality does not set it.
- R6: Mask bits other than 0, 3, 4 and 15 are always 0, and `acc_fault` is 1 exactly when the presented mask is nonzero.
- R7: While reset is high and in the first cycle after it, `out_valid`, `acc_fault`, `ring_out` and `viol_mask` are all 0.
- R8: `in_ready` is 1 when no result is held or `out_ready` is 1. A request accepted on a clock edge is presented with `out_valid` high right after that edge. A held result that is taken with no new request leaves `out_valid` low.
- R9: While `out_valid` is 1 and `out_ready` is 0, all outputs keep their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request is present |
| in_ready | output | 1 | Block can take a request this cycle |
| sd_r1 | input | 3 | Descriptor first bracket limit |
| sd_r2 | input | 3 | Descriptor second bracket limit |
| sd_r3 | input | 3 | Descriptor third bracket limit |
| sd_rd_ok | input | 1 | Descriptor read-permit flag |
| sd_bound | input | 14 | Descriptor segment bound, in 16-word blocks |
| eff_ring | input | 3 | Effective ring of the access |
| tgt_seg | input | 15 | Target segment number |
| proc_ring | input | 3 | Ring of the running procedure |
| proc_seg | input | 15 | Segment of the running procedure |
| word_off | input | 18 | Computed word offset in the segment |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| viol_mask | output | 16 | Coded violation mask |
| acc_fault | output | 1 | Combined access fault |
| ring_out | output | 3 | Effective ring after adjustment |

## Verification
The properties assume that request fields are stable and known in any cycle where `in_valid` is high. They also assume that `out_ready` is known at every clock edge once reset is released. The bench meets these conditions by driving every input away from the clock edge and by holding the fields steady for a whole cycle. Directed requests cover ring equality against the second limit, bound equality against its neighbour, and denied permission with both equal and differing segments. Random requests run with a random `out_ready`, so that stalls, back-to-back transfers and empty cycles all occur.

// File: rtl/ring_chk_pkg.sv
package ring_chk_pkg;

  localparam int RING_W = 3;
  localparam int SEG_W  = 15;
  localparam int OFF_W  = 18;
  localparam int BND_W  = 14;
  localparam int MASK_W = 16;
  localparam int BLK_SHIFT = 4;

  localparam int BIT_ORDER   = 0;
  localparam int BIT_RDBRK   = 3;
  localparam int BIT_NOREAD  = 4;
  localparam int BIT_BOUND   = 15;

  typedef struct packed {
    logic order_bad;
    logic rd_bracket_bad;
    logic no_read;
    logic out_of_bound;
  } viol_flags_t;

  function automatic logic [MASK_W-1:0] encode_mask(input viol_flags_t f);
    logic [MASK_W-1:0] m;
    m = '0;
    m[BIT_ORDER]  = f.order_bad;
    m[BIT_RDBRK]  = f.rd_bracket_bad;
    m[BIT_NOREAD] = f.no_read;
    m[BIT_BOUND]  = f.out_of_bound;
    return m;
  endfunction

endpackage

// File: rtl/rcc_bracket_eval.sv
module rcc_bracket_eval #(
  parameter int RING_W = 3
) (
  input  logic [RING_W-1:0] lim1,
  input  logic [RING_W-1:0] lim2,
  input  logic [RING_W-1:0] lim3,
  input  logic [RING_W-1:0] ring_in,
  output logic              order_bad,
  output logic              bracket_bad
);

  logic lo_ok;
  logic hi_ok;

  always_comb begin
    lo_ok       = (lim1 <= lim2);
    hi_ok       = (lim2 <= lim3);
    order_bad   = !(lo_ok && hi_ok);
    bracket_bad = (ring_in > lim2);
  end

endmodule

// File: rtl/rcc_permit_eval.sv
module rcc_permit_eval #(
  parameter int RING_W = 3,
  parameter int SEG_W  = 15
) (
  input  logic              rd_ok,
  input  logic [RING_W-1:0] ring_in,
  input  logic [RING_W-1:0] pr_ring,
  input  logic [SEG_W-1:0]  pr_seg,
  input  logic [SEG_W-1:0]  tg_seg,
  output logic [RING_W-1:0] ring_adj,
  output logic              no_read
);

  logic same_seg;

  always_comb begin
    same_seg = (pr_seg == tg_seg);
    if (rd_ok) begin
      ring_adj = ring_in;
      no_read  = 1'b0;
    end else begin
      ring_adj = pr_ring;
      no_read  = !same_seg;
    end
  end

endmodule

// File: rtl/rcc_bound_eval.sv
module rcc_bound_eval #(
  parameter int OFF_W     = 18,
  parameter int BND_W     = 14,
  parameter int BLK_SHIFT = 4
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [BND_W-1:0] bound,
  output logic             over
);

  localparam int HI_BIT = (OFF_W - BLK_SHIFT > BND_W) ? BND_W : OFF_W - BLK_SHIFT;

  logic [OFF_W-1:0] shifted;
  logic [BND_W-1:0] blk;

  always_comb begin
    shifted = offset >> BLK_SHIFT;
    blk     = '0;
    blk[HI_BIT-1:0] = shifted[HI_BIT-1:0];
    over    = (blk > bound);
  end

endmodule

// File: rtl/rcc_out_stage.sv
module rcc_out_stage #(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  logic              vld_q;
  logic [DATA_W-1:0] dat_q;
  logic              take;

  always_comb begin
    s_ready = !vld_q || m_ready;
    take    = s_valid && s_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (take) begin
        vld_q <= 1'b1;
        dat_q <= s_data;
      end else if (m_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign m_valid = vld_q;
  assign m_data  = dat_q;

endmodule

// File: rtl/ring_access_chk.sv
module ring_access_chk
  import ring_chk_pkg::*;
#(
  parameter int P_RING_W = RING_W,
  parameter int P_SEG_W  = SEG_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_BND_W  = BND_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [P_RING_W-1:0] sd_r1,
  input  logic [P_RING_W-1:0] sd_r2,
  input  logic [P_RING_W-1:0] sd_r3,
  input  logic                sd_rd_ok,
  input  logic [P_BND_W-1:0]  sd_bound,
  input  logic [P_RING_W-1:0] eff_ring,
  input  logic [P_SEG_W-1:0]  tgt_seg,
  input  logic [P_RING_W-1:0] proc_ring,
  input  logic [P_SEG_W-1:0]  proc_seg,
  input  logic [P_OFF_W-1:0]  word_off,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MASK_W-1:0]   viol_mask,
  output logic                acc_fault,
  output logic [P_RING_W-1:0] ring_out
);

  localparam int PAY_W = MASK_W + 1 + P_RING_W;

  viol_flags_t         flags;
  logic [MASK_W-1:0]   mask_c;
  logic [P_RING_W-1:0] ring_c;
  logic [PAY_W-1:0]    pay_c;
  logic [PAY_W-1:0]    pay_q;

  rcc_bracket_eval #(.RING_W(P_RING_W)) u_brk (
    .lim1        (sd_r1),
    .lim2        (sd_r2),
    .lim3        (sd_r3),
    .ring_in     (eff_ring),
    .order_bad   (flags.order_bad),
    .bracket_bad (flags.rd_bracket_bad)
  );

  rcc_permit_eval #(.RING_W(P_RING_W), .SEG_W(P_SEG_W)) u_perm (
    .rd_ok    (sd_rd_ok),
    .ring_in  (eff_ring),
    .pr_ring  (proc_ring),
    .pr_seg   (proc_seg),
    .tg_seg   (tgt_seg),
    .ring_adj (ring_c),
    .no_read  (flags.no_read)
  );

  rcc_bound_eval #(.OFF_W(P_OFF_W), .BND_W(P_BND_W), .BLK_SHIFT(BLK_SHIFT)) u_bnd (
    .offset (word_off),
    .bound  (sd_bound),
    .over   (flags.out_of_bound)
  );

  always_comb begin
    mask_c = encode_mask(flags);
    pay_c  = {mask_c, |mask_c, ring_c};
  end

  rcc_out_stage #(.DATA_W(PAY_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_c),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_q)
  );

  assign viol_mask = pay_q[PAY_W-1 -: MASK_W];
  assign acc_fault = pay_q[P_RING_W];
  assign ring_out  = pay_q[P_RING_W-1:0];

endmodule

// File: rtl/ring_access_chk_sva.sv
module ring_access_chk_sva
  import ring_chk_pkg::*;
#(
  parameter int P_RING_W = RING_W,
  parameter int P_SEG_W  = SEG_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_BND_W  = BND_W
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [P_RING_W-1:0] sd_r1,
  input logic [P_RING_W-1:0] sd_r2,
  input logic [P_RING_W-1:0] sd_r3,
  input logic                sd_rd_ok,
  input logic [P_BND_W-1:0]  sd_bound,
  input logic [P_RING_W-1:0] eff_ring,
  input logic [P_SEG_W-1:0]  tgt_seg,
  input logic [P_RING_W-1:0] proc_ring,
  input logic [P_SEG_W-1:0]  proc_seg,
  input logic [P_OFF_W-1:0]  word_off,
  input logic                out_valid,
  input logic                out_ready,
  input logic [MASK_W-1:0]   viol_mask,
  input logic                acc_fault,
  input logic [P_RING_W-1:0] ring_out
);

  localparam logic [MASK_W-1:0] USED = (MASK_W'(1) << BIT_ORDER) | (MASK_W'(1) << BIT_RDBRK)
                                     | (MASK_W'(1) << BIT_NOREAD) | (MASK_W'(1) << BIT_BOUND);

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  order_bit_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> viol_mask[BIT_ORDER] == (($past(sd_r1) > $past(sd_r2)) || ($past(sd_r2) > $past(sd_r3))));

  // R2
  rd_bracket_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> viol_mask[BIT_RDBRK] == ($past(eff_ring) > $past(sd_r2)));

  // R3
  ring_adj_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> ring_out == ($past(sd_rd_ok) ? $past(eff_ring) : $past(proc_ring)));

  // R4
  no_read_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> viol_mask[BIT_NOREAD] == (!$past(sd_rd_ok) && ($past(proc_seg) != $past(tgt_seg))));

  // R5
  bound_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> viol_mask[BIT_BOUND] == ((P_BND_W'($past(word_off) >> BLK_SHIFT)) > $past(sd_bound)));

  // R6
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_mask & ~USED) == '0);

  // R6
  fault_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (acc_fault == (viol_mask != '0)));

  // R7
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && viol_mask == '0 && !acc_fault && ring_out == '0));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  // R8
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(viol_mask) && $stable(ring_out) && $stable(acc_fault)));

endmodule

bind ring_access_chk ring_access_chk_sva #(
  .P_RING_W(P_RING_W), .P_SEG_W(P_SEG_W), .P_OFF_W(P_OFF_W), .P_BND_W(P_BND_W)
) u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .sd_r1(sd_r1), .sd_r2(sd_r2), .sd_r3(sd_r3), .sd_rd_ok(sd_rd_ok), .sd_bound(sd_bound),
  .eff_ring(eff_ring), .tgt_seg(tgt_seg), .proc_ring(proc_ring), .proc_seg(proc_seg),
  .word_off(word_off), .out_valid(out_valid), .out_ready(out_ready),
  .viol_mask(viol_mask), .acc_fault(acc_fault), .ring_out(ring_out)
);

// File: tb/ring_access_chk_tb.sv
module ring_access_chk_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  sd_r1 = '0, sd_r2 = '0, sd_r3 = '0;
  logic        sd_rd_ok = 1'b1;
  logic [13:0] sd_bound = '0;
  logic [2:0]  eff_ring = '0;
  logic [14:0] tgt_seg = '0;
  logic [2:0]  proc_ring = '0;
  logic [14:0] proc_seg = '0;
  logic [17:0] word_off = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] viol_mask;
  logic        acc_fault;
  logic [2:0]  ring_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit          m_valid = 0;
  int          m_mask  = 0;
  bit          m_fault = 0;
  int          m_ring  = 0;
  bit          stalled = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_access_chk u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .sd_r1(sd_r1), .sd_r2(sd_r2), .sd_r3(sd_r3), .sd_rd_ok(sd_rd_ok), .sd_bound(sd_bound),
    .eff_ring(eff_ring), .tgt_seg(tgt_seg), .proc_ring(proc_ring), .proc_seg(proc_seg),
    .word_off(word_off), .out_valid(out_valid), .out_ready(out_ready),
    .viol_mask(viol_mask), .acc_fault(acc_fault), .ring_out(ring_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural evaluation of the currently driven request
  task automatic ref_eval(output int mask, output int ring);
    int blk;
    mask = 0;
    if (!(int'(sd_r1) <= int'(sd_r2) && int'(sd_r2) <= int'(sd_r3))) mask += 1;       // R1 bit 0
    if (int'(eff_ring) > int'(sd_r2)) mask += 8;                                       // R2 bit 3
    if (!sd_rd_ok && proc_seg != tgt_seg) mask += 16;                                  // R4 bit 4
    blk = int'(word_off) / 16;
    if (blk > int'(sd_bound)) mask += 32768;                                           // R5 bit 15
    ring = sd_rd_ok ? int'(eff_ring) : int'(proc_ring);                                // R3
  endtask

  // model step for the clock edge that just passed, using the inputs held over it
  task automatic model_step();
    int mk, rg;
    bit take;
    take = in_valid && (!m_valid || out_ready);
    stalled = m_valid && !out_ready;
    if (take) begin
      ref_eval(mk, rg);
      m_valid = 1; m_mask = mk; m_ring = rg; m_fault = (mk != 0);
    end else if (out_ready) begin
      m_valid = 0;
    end
  endtask

  task automatic compare();
    string rq;
    rq = stalled ? "R9" : "R8";
    chk(rq, out_valid, m_valid);
    chk("R8 in_ready", in_ready, (!m_valid || out_ready));
    if (m_valid) begin
      if (viol_mask[0] != m_mask[0])   chk(stalled ? "R9" : "R1", viol_mask[0], m_mask[0]);
      else if (viol_mask[3] != m_mask[3]) chk(stalled ? "R9" : "R2", viol_mask[3], m_mask[3]);
      else if (viol_mask[4] != m_mask[4]) chk(stalled ? "R9" : "R4", viol_mask[4], m_mask[4]);
      else if (viol_mask[15] != m_mask[15]) chk(stalled ? "R9" : "R5", viol_mask[15], m_mask[15]);
      else chk("R6 mask", viol_mask, m_mask);
      chk("R6 fault", acc_fault, m_fault);
      chk(stalled ? "R9" : "R3", ring_out, m_ring);
    end
  endtask

  task automatic drive(input bit v, input bit rdy, input int r1, input int r2, input int r3,
                       input bit rd, input int bnd, input int er, input int ts,
                       input int pr, input int ps, input int off);
    @(negedge clk);
    model_step();
    in_valid = v; out_ready = rdy;
    sd_r1 = 3'(r1); sd_r2 = 3'(r2); sd_r3 = 3'(r3); sd_rd_ok = rd;
    sd_bound = 14'(bnd); eff_ring = 3'(er); tgt_seg = 15'(ts);
    proc_ring = 3'(pr); proc_seg = 15'(ps); word_off = 18'(off);
    #1;
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state while reset is high
    chk("R7 valid", out_valid, 0);
    chk("R7 mask", viol_mask, 0);
    chk("R7 fault", acc_fault, 0);
    chk("R7 ring", ring_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 after", {out_valid, acc_fault, ring_out, viol_mask}, 0);

    // directed corners, consumer always ready
    drive(1,1, 1,2,3, 1, 100, 2, 5, 4, 5, 100*16+15);  // clean, R5 equality
    drive(1,1, 1,2,3, 1, 100, 3, 5, 4, 5, 101*16);     // R2 ring above, R5 one over
    drive(1,1, 3,2,4, 1, 0, 0, 1, 0, 1, 15);           // R1 first > second
    drive(1,1, 1,5,4, 1, 0, 0, 1, 0, 1, 16);           // R1 second > third, R5 over
    drive(1,1, 6,6,6, 1, 16383, 6, 7, 1, 7, 262143);   // equal rings, max offset at max bound
    drive(1,1, 1,2,3, 0, 50, 7, 9, 1, 9, 0);           // R3 ring swap, same seg, R2 uses original
    drive(1,1, 1,2,3, 0, 50, 0, 9, 5, 10, 0);          // R4 differing seg
    drive(1,1, 7,0,0, 0, 0, 7, 0, 3, 32767, 262143);   // all bits set
    // R9 stall: accept, then hold several cycles, then drain
    drive(1,0, 1,1,1, 0, 3, 4, 2, 6, 3, 64);
    drive(1,0, 0,0,0, 1, 9, 0, 0, 0, 0, 0);
    drive(0,0, 0,0,0, 1, 9, 0, 0, 0, 0, 0);
    drive(0,1, 0,0,0, 1, 9, 0, 0, 0, 0, 0);
    drive(0,1, 0,0,0, 1, 9, 0, 0, 0, 0, 0);             // R8 drained

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int ts, ps;
      ts = $urandom_range(0, 32767);
      ps = ($urandom_range(0, 1) == 1) ? ts : $urandom_range(0, 32767);
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 1) == 1, $urandom_range(0, 16383),
            $urandom_range(0, 7), ts, $urandom_range(0, 7), ps,
            $urandom_range(0, 262143));
    end
    drive(0,1, 0,0,0, 1, 0, 0, 0, 0, 0, 0);
    drive(0,1, 0,0,0, 1, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule